// File: doc/BRIEF.md
# Dual-Lane Word ALU with Lane Masking and Skip Test

This block computes one arithmetic or logic result per enabled cycle for an 18-bit word made of two 9-bit lanes. The low lane (bits 8:0) is the x lane and the high lane (bits 17:9) is the y lane. A 3-bit function code picks a binary operation on two source operands. One function code opens a unary group that works on the first operand, and a 3-bit sub-code chooses the operation in that group. Function codes and sub-codes with no operation assigned raise an undefined flag.

A 2-bit masking mode turns into a per-lane write enable for the destination. The same mode decides which lanes count in a zero/nonzero test of the first operand. That test drives the skip condition of the conditional-skip instructions, and the block reports the cycle cost of the instruction it evaluated. All outputs are registered and are updated only in cycles where the enable is high.

Top module: `lane_alu`

## Requirements
- R1: Function 0 adds and function 1 subtracts (first minus second) each 9-bit lane on its own. Each lane wraps modulo 512, and no carry or borrow passes between lanes.
- R2: Functions 2, 3 and 4 give the bitwise AND, OR and XOR of the two operands.
- R3: Functions 5 and 6 give result 0 with undef = 1. For every defined operation, undef = 0.
- R4: Function 7 with sub-code 0 gives the bitwise NOT of the first operand. Sub-code 1 shifts the whole 18-bit first operand right by one and fills bit 17 with 0.
- R5: Function 7 with sub-code 2 adds 1 to each lane of the first operand, and sub-code 3 subtracts 1 from each lane. Each lane wraps on its own.
- R6: Function 7 with sub-code 4 adds 1 to the first operand as one 18-bit value, and sub-code 5 subtracts 1 from it the same way. Carry and borrow cross from the x lane into the y lane, and the result wraps modulo 2^18.
- R7: Function 7 with sub-code 6 or 7 gives x lane 0773 (octal), y lane 0440 (octal) and undef = 1.
- R8: For an operation that is not a test, lane_we[0] (x lane) and lane_we[1] (y lane) depend on the mode: mode 0 gives 2'b11, mode 1 gives 2'b01, mode 2 gives 2'b10, and mode 3 (scalar) gives 2'b11.
- R9: When is_test = 1, the test counts the first operand's x lane unless the mode is 2, and its y lane unless the mode is 1. The operand is nonzero if any counted lane is nonzero. skip is set to that nonzero condition when skip_nz = 1, and to its inverse when skip_nz = 0. A test also gives result 0, undef 0 and lane_we 2'b00. When is_test = 0, skip is 0.
- R10: cost is 4 for an operation that is not a test. For a test, cost is 7 when the skip is taken and 6 when it is not.
- R11: Reset clears every output. An enabled cycle updates all outputs at the next clock edge and sets out_valid. A cycle with en = 0 keeps result, undef, lane_we, skip and cost unchanged and clears out_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| en | input | 1 | Evaluate the inputs this cycle |
| opa | input | 18 | First operand; also the operand of the unary group and of the test |
| opb | input | 18 | Second operand |
| fn | input | 3 | Function code |
| sub | input | 3 | Unary sub-code, used when fn = 7 |
| mode | input | 2 | Masking mode |
| is_test | input | 1 | Evaluate the zero/nonzero skip test instead of an ALU operation |
| skip_nz | input | 1 | Test polarity: 1 = skip when nonzero, 0 = skip when zero |
| result | output | 18 | Registered result word |
| undef | output | 1 | Undefined operation flag |
| lane_we | output | 2 | Destination lane write enable, bit 0 = x, bit 1 = y |
| skip | output | 1 | Skip condition of a test |
| cost | output | 4 | Cycle cost of the evaluated instruction |
| out_valid | output | 1 | Outputs were updated by the previous enabled cycle |

## Verification
The assertions check, on every cycle, that each reserved function code produces a zero result with the undefined flag, that the flag never appears for a defined operation, that x-only mode maps to the x-lane write enable, that cost agrees with whether a skip was taken, and that outputs hold when the enable is low. The arithmetic itself can only be shown by the bench's scenarios. Those scenarios cover lane wrap without carry between lanes, scalar carry and borrow crossing the lane boundary, shift zero fill, the fixed result of undefined unary codes, and every mode crossed with both test polarities, checked against a reference model.

// File: rtl/lane_alu_pkg.sv
package lane_alu_pkg;
  typedef enum logic [2:0] {
    FN_ADD = 3'd0, FN_SUB = 3'd1, FN_AND = 3'd2, FN_OR = 3'd3,
    FN_XOR = 3'd4, FN_RSV5 = 3'd5, FN_RSV6 = 3'd6, FN_UNARY = 3'd7
  } fn_e;

  typedef enum logic [2:0] {
    UN_NOT = 3'd0, UN_SHR = 3'd1, UN_INCV = 3'd2, UN_DECV = 3'd3,
    UN_INCS = 3'd4, UN_DECS = 3'd5, UN_RSV6 = 3'd6, UN_RSV7 = 3'd7
  } un_e;

  typedef enum logic [1:0] {
    MD_BOTH = 2'd0, MD_XONLY = 2'd1, MD_YONLY = 2'd2, MD_SCALAR = 2'd3
  } mode_e;

  localparam int COST_W    = 4;
  localparam int COST_ALU  = 4;
  localparam int COST_SKIP = 7;
  localparam int COST_STAY = 6;
endpackage

// File: rtl/lane_alu_core.sv
module lane_alu_core
  import lane_alu_pkg::*;
#(
  parameter int LANE_W  = 9,
  parameter int MAGIC_X = 'o773,
  parameter int MAGIC_Y = 'o440
) (
  input  logic [2*LANE_W-1:0] opa,
  input  logic [2*LANE_W-1:0] opb,
  input  logic [2:0]          fn,
  input  logic [2:0]          sub,
  output logic [2*LANE_W-1:0] res,
  output logic                bad
);
  localparam int WORD_W = 2 * LANE_W;
  localparam int NLANE  = 2;

  logic [WORD_W-1:0] add_w, sub_w, incv_w, decv_w;

  // lane-local arithmetic: each lane carries into nothing
  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    assign add_w[l*LANE_W +: LANE_W]  = opa[l*LANE_W +: LANE_W] + opb[l*LANE_W +: LANE_W];
    assign sub_w[l*LANE_W +: LANE_W]  = opa[l*LANE_W +: LANE_W] - opb[l*LANE_W +: LANE_W];
    assign incv_w[l*LANE_W +: LANE_W] = opa[l*LANE_W +: LANE_W] + LANE_W'(1);
    assign decv_w[l*LANE_W +: LANE_W] = opa[l*LANE_W +: LANE_W] - LANE_W'(1);
  end

  logic [WORD_W-1:0] un_res;
  logic              un_bad;

  always_comb begin
    un_bad = 1'b0;
    case (sub)
      UN_NOT:  un_res = ~opa;
      UN_SHR:  un_res = {1'b0, opa[WORD_W-1:1]};
      UN_INCV: un_res = incv_w;
      UN_DECV: un_res = decv_w;
      UN_INCS: un_res = opa + WORD_W'(1);
      UN_DECS: un_res = opa - WORD_W'(1);
      default: begin
        un_res = {LANE_W'(MAGIC_Y), LANE_W'(MAGIC_X)};
        un_bad = 1'b1;
      end
    endcase
  end

  always_comb begin
    bad = 1'b0;
    case (fn)
      FN_ADD:   res = add_w;
      FN_SUB:   res = sub_w;
      FN_AND:   res = opa & opb;
      FN_OR:    res = opa | opb;
      FN_XOR:   res = opa ^ opb;
      FN_UNARY: begin
        res = un_res;
        bad = un_bad;
      end
      default: begin
        res = '0;
        bad = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/lane_alu_mask.sv
module lane_alu_mask
  import lane_alu_pkg::*;
#(
  parameter int LANE_W = 9
) (
  input  logic [2*LANE_W-1:0] opa,
  input  logic [1:0]          mode,
  input  logic                is_test,
  input  logic                skip_nz,
  output logic [1:0]          we,
  output logic                skip,
  output logic [COST_W-1:0]   cost
);
  logic x_sig, y_sig, nonzero;

  assign x_sig   = (mode != MD_YONLY);
  assign y_sig   = (mode != MD_XONLY);
  assign nonzero = (x_sig && (opa[LANE_W-1:0] != '0)) ||
                   (y_sig && (opa[2*LANE_W-1:LANE_W] != '0));
  assign skip    = is_test && (skip_nz ? nonzero : !nonzero);

  always_comb begin
    if (is_test) begin
      we = 2'b00;
    end else begin
      case (mode)
        MD_XONLY: we = 2'b01;
        MD_YONLY: we = 2'b10;
        default:  we = 2'b11;
      endcase
    end
  end

  always_comb begin
    if (!is_test)  cost = COST_W'(COST_ALU);
    else if (skip) cost = COST_W'(COST_SKIP);
    else           cost = COST_W'(COST_STAY);
  end
endmodule

// File: rtl/lane_alu.sv
module lane_alu
  import lane_alu_pkg::*;
#(
  parameter int LANE_W = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic [2*LANE_W-1:0] opa,
  input  logic [2*LANE_W-1:0] opb,
  input  logic [2:0]          fn,
  input  logic [2:0]          sub,
  input  logic [1:0]          mode,
  input  logic                is_test,
  input  logic                skip_nz,
  output logic [2*LANE_W-1:0] result,
  output logic                undef,
  output logic [1:0]          lane_we,
  output logic                skip,
  output logic [3:0]          cost,
  output logic                out_valid
);
  localparam int WORD_W = 2 * LANE_W;

  // reset: asserted asynchronously, released through two flops
  logic rst_q1, rst_q2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1 <= 1'b0;
      rst_q2 <= 1'b0;
    end else begin
      rst_q1 <= 1'b1;
      rst_q2 <= rst_q1;
    end
  end

  logic [WORD_W-1:0] core_res;
  logic              core_bad;
  logic [1:0]        m_we;
  logic              m_skip;
  logic [COST_W-1:0] m_cost;

  lane_alu_core #(.LANE_W(LANE_W)) u_core (
    .opa(opa), .opb(opb), .fn(fn), .sub(sub), .res(core_res), .bad(core_bad)
  );

  lane_alu_mask #(.LANE_W(LANE_W)) u_mask (
    .opa(opa), .mode(mode), .is_test(is_test), .skip_nz(skip_nz),
    .we(m_we), .skip(m_skip), .cost(m_cost)
  );

  logic [WORD_W-1:0] result_d;
  logic              undef_d, skip_d, valid_d;
  logic [1:0]        we_d;
  logic [3:0]        cost_d;

  always_comb begin
    result_d = result;
    undef_d  = undef;
    we_d     = lane_we;
    skip_d   = skip;
    cost_d   = cost;
    valid_d  = en;
    if (en) begin
      result_d = is_test ? '0 : core_res;
      undef_d  = !is_test && core_bad;
      we_d     = m_we;
      skip_d   = m_skip;
      cost_d   = m_cost;
    end
  end

  always_ff @(posedge clk or negedge rst_q2) begin
    if (!rst_q2) begin
      result    <= '0;
      undef     <= 1'b0;
      lane_we   <= 2'b00;
      skip      <= 1'b0;
      cost      <= '0;
      out_valid <= 1'b0;
    end else begin
      result    <= result_d;
      undef     <= undef_d;
      lane_we   <= we_d;
      skip      <= skip_d;
      cost      <= cost_d;
      out_valid <= valid_d;
    end
  end
endmodule

// File: rtl/lane_alu_chk.sv
module lane_alu_chk #(
  parameter int LANE_W = 9
) (
  input logic                clk,
  input logic                rst_n,
  input logic                en,
  input logic [2*LANE_W-1:0] opa,
  input logic [2:0]          fn,
  input logic [1:0]          mode,
  input logic                is_test,
  input logic                skip_nz,
  input logic [2*LANE_W-1:0] result,
  input logic                undef,
  input logic [1:0]          lane_we,
  input logic                skip,
  input logic [3:0]          cost,
  input logic                out_valid
);
  assert_rsv_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !$past(is_test) && ($past(fn) == 3'd5 || $past(fn) == 3'd6))
      |-> (result == '0 && undef));

  // R3, R7: the flag only follows reserved or unary codes
  assert_undef_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && undef) |-> ($past(fn) >= 3'd5 && !$past(is_test)));

  assert_xonly_we_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !$past(is_test) && $past(mode) == 2'd1) |-> (lane_we == 2'b01));

  assert_skip_xonly_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(is_test) && $past(mode) == 2'd1 && !$past(skip_nz) &&
     $past(opa[LANE_W-1:0]) == '0) |-> skip);

  assert_cost_alu_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !$past(is_test)) |-> (cost == 4'd4 && !skip));

  assert_cost_test_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(is_test)) |-> (cost == (skip ? 4'd7 : 4'd6)));

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en) |-> (!out_valid && $stable(result) && $stable(cost)));
endmodule

bind lane_alu lane_alu_chk #(.LANE_W(LANE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .opa(opa), .fn(fn), .mode(mode),
  .is_test(is_test), .skip_nz(skip_nz), .result(result), .undef(undef),
  .lane_we(lane_we), .skip(skip), .cost(cost), .out_valid(out_valid)
);

// File: tb/lane_alu_tb.sv
module lane_alu_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        en, is_test, skip_nz;
  logic [17:0] opa, opb;
  logic [2:0]  fn, sub;
  logic [1:0]  mode;
  logic [17:0] result;
  logic        undef, skip, out_valid;
  logic [1:0]  lane_we;
  logic [3:0]  cost;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lane_alu u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .opa(opa), .opb(opb), .fn(fn), .sub(sub),
    .mode(mode), .is_test(is_test), .skip_nz(skip_nz), .result(result),
    .undef(undef), .lane_we(lane_we), .skip(skip), .cost(cost), .out_valid(out_valid)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [17:0] lanes(logic [8:0] y, logic [8:0] x);
    return {y, x};
  endfunction

  // reference model written from the requirements
  function automatic logic [18:0] model(logic [2:0] f, logic [2:0] s, logic [17:0] a, logic [17:0] b);
    logic [8:0] ax = a[8:0], ay = a[17:9], bx = b[8:0], by = b[17:9];
    case (f)
      3'd0: return {1'b0, lanes(ay + by, ax + bx)};
      3'd1: return {1'b0, lanes(ay - by, ax - bx)};
      3'd2: return {1'b0, a & b};
      3'd3: return {1'b0, a | b};
      3'd4: return {1'b0, a ^ b};
      3'd7: case (s)
        3'd0: return {1'b0, ~a};
        3'd1: return {1'b0, a >> 1};
        3'd2: return {1'b0, lanes(ay + 9'd1, ax + 9'd1)};
        3'd3: return {1'b0, lanes(ay - 9'd1, ax - 9'd1)};
        3'd4: return {1'b0, a + 18'd1};
        3'd5: return {1'b0, a - 18'd1};
        default: return {1'b1, lanes(9'o440, 9'o773)};
      endcase
      default: return {1'b1, 18'd0};
    endcase
  endfunction

  function automatic string req_of(logic [2:0] f, logic [2:0] s);
    if (f <= 3'd1) return "R1";
    if (f <= 3'd4) return "R2";
    if (f != 3'd7) return "R3";
    if (s <= 3'd1) return "R4";
    if (s <= 3'd3) return "R5";
    if (s <= 3'd5) return "R6";
    return "R7";
  endfunction

  // drive on a falling edge, check on the next falling edge
  task automatic alu_op(logic [2:0] f, logic [2:0] s, logic [17:0] a, logic [17:0] b, logic [1:0] m);
    logic [18:0] e = model(f, s, a, b);
    string r = req_of(f, s);
    en = 1; is_test = 0; skip_nz = 0; fn = f; sub = s; opa = a; opb = b; mode = m;
    @(negedge clk);
    check({r, " result"}, 32'(result), 32'(e[17:0]));
    check({r, " undef"}, 32'(undef), 32'(e[18]));
    check("R8 lane_we", 32'(lane_we), (m == 2'd1) ? 32'd1 : (m == 2'd2) ? 32'd2 : 32'd3);
    check("R10 alu cost", 32'(cost), 32'd4);
    check("R11 valid", 32'(out_valid), 32'd1);
  endtask

  task automatic test_op(logic [17:0] a, logic [1:0] m, logic pol);
    logic nz = ((m != 2'd2) && a[8:0] != 0) || ((m != 2'd1) && a[17:9] != 0);
    logic tk = pol ? nz : !nz;
    en = 1; is_test = 1; skip_nz = pol; fn = 3'd0; sub = 3'd0; opa = a; opb = 18'h3ffff; mode = m;
    @(negedge clk);
    check("R9 skip", 32'(skip), 32'(tk));
    check("R9 test we", 32'(lane_we), 32'd0);
    check("R9 test result", 32'(result), 32'd0);
    check("R10 test cost", 32'(cost), tk ? 32'd7 : 32'd6);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : stim
    logic [17:0] hold_r;
    void'($urandom(32'd1234));
    rst_n = 0; en = 0; is_test = 0; skip_nz = 0; fn = 0; sub = 0; opa = 0; opb = 0; mode = 0;
    repeat (3) @(negedge clk);
    check("R11 reset result", 32'(result), 32'd0);
    check("R11 reset valid", 32'(out_valid), 32'd0);
    check("R11 reset cost", 32'(cost), 32'd0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // directed corners
    alu_op(3'd0, 3'd0, lanes(9'o777, 9'o777), lanes(9'd1, 9'd1), 2'd0); // R1 lane wrap, no carry
    alu_op(3'd1, 3'd0, lanes(9'd0, 9'd0), lanes(9'd0, 9'd1), 2'd1);     // R1 borrow stays in x lane
    alu_op(3'd4, 3'd0, 18'h2aaaa, 18'h3ffff, 2'd2);                     // R2
    alu_op(3'd5, 3'd0, 18'h12345, 18'h0abcd, 2'd3);                     // R3
    alu_op(3'd6, 3'd0, 18'h3ffff, 18'h3ffff, 2'd0);                     // R3
    alu_op(3'd7, 3'd1, 18'h3ffff, 18'd0, 2'd0);                         // R4 zero fill
    alu_op(3'd7, 3'd0, 18'h00f0f, 18'd0, 2'd0);                         // R4
    alu_op(3'd7, 3'd2, lanes(9'o777, 9'd5), 18'd0, 2'd0);               // R5
    alu_op(3'd7, 3'd3, lanes(9'd0, 9'd0), 18'd0, 2'd0);                 // R5
    alu_op(3'd7, 3'd4, lanes(9'd0, 9'o777), 18'd0, 2'd3);               // R6 carry crosses
    alu_op(3'd7, 3'd5, lanes(9'd1, 9'd0), 18'd0, 2'd3);                 // R6 borrow crosses
    alu_op(3'd7, 3'd4, 18'h3ffff, 18'd0, 2'd3);                         // R6 wrap
    alu_op(3'd7, 3'd6, 18'h1, 18'd0, 2'd0);                             // R7
    alu_op(3'd7, 3'd7, 18'h0, 18'd0, 2'd0);                             // R7

    // R9: every mode, both polarities, lane patterns
    for (int m = 0; m < 4; m++)
      for (int p = 0; p < 2; p++) begin
        test_op(18'd0, 2'(m), 1'(p));
        test_op(lanes(9'd0, 9'd3), 2'(m), 1'(p));
        test_op(lanes(9'd3, 9'd0), 2'(m), 1'(p));
      end

    // R11: enable low holds outputs
    alu_op(3'd3, 3'd0, 18'h01234, 18'h10000, 2'd0);
    hold_r = result;
    en = 0; fn = 3'd7; sub = 3'd6; opa = 18'h3ffff; is_test = 1;
    @(negedge clk);
    @(negedge clk);
    check("R11 hold result", 32'(result), 32'(hold_r));
    check("R11 hold undef", 32'(undef), 32'd0);
    check("R11 hold valid", 32'(out_valid), 32'd0);

    // constrained random mix
    for (int i = 0; i < 600; i++) begin
      logic [17:0] a = 18'($urandom), b = 18'($urandom);
      if ($urandom_range(0, 7) == 0) a = {a[17:9], 9'o777};
      if ($urandom_range(0, 3) == 0)
        test_op(($urandom_range(0, 1) != 0) ? a : (a & 18'h001ff), 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)));
      else
        alu_op(3'($urandom_range(0, 7)), 3'($urandom_range(0, 7)), a, b, 2'($urandom_range(0, 3)));
    end

    done = 1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule